// File: doc/BRIEF.md
# Sector-Buffered Nonvolatile Program Engine

This block is the device side of a byte-wide nonvolatile memory with a 512K x 8 address space, written as synthesizable logic. It sits behind a parallel asynchronous-style bus made of active-low chip enable, output enable and write enable strobes, a 19-bit address and 8-bit data. All strobes are sampled on the block clock. Writes are not sent to the array at once. They are collected into a 256-byte page buffer that belongs to one sector. When the bus stops supplying bytes for a programmable number of clock cycles, the block commits the page on its own. It first erases the whole sector to 8'hFF and then writes the bytes that were loaded.

While the commit runs, the buffer and the sector number are held inside the block, so the host bus is free. A read in that window returns a status word and not array data. Bit 7 is the complement of bit 7 of the last loaded byte. Bit 6 flips on every new read access. Bits 5 to 0 are zero. Host software polls until the true byte comes back. The stored array is scaled down to `MODEL_SECTORS` sectors, which the low sector-address bits select; the higher sector bits alias onto them. The bus is a strobe bus and not a stream, so there is no valid/ready handshake. A write cannot be refused, and loads that arrive while the block is busy are dropped.

Top module: `spb_engine`

## Requirements
- R1: With ce_n and oe_n both low, dout_en is 1 and, when the block is idle, dout shows the stored byte at addr. With ce_n or oe_n high, dout_en is 0, which represents a high-impedance bus.
- R2: A byte load is taken once, on the first clock where ce_n=0, we_n=0 and oe_n=1 all hold together. If oe_n is low or ce_n is high, no load is taken and no commit follows.
- R3: A load stores din at buffer offset addr[7:0] and binds the page to sector addr[18:8].
- R4: The commit starts when LOAD_TIMEOUT+1 clock edges pass after the last accepted load with no further load. Every accepted load restarts this window.
- R5: A commit erases the whole bound sector to 8'hFF, then writes every loaded offset with its byte. Offsets that were not loaded read back 8'hFF. Other sectors do not change.
- R6: While busy, a read returns bit 7 equal to the complement of bit 7 of the last loaded byte and bits 5..0 equal to zero.
- R7: While busy, bit 6 of the read data flips on each new read access (a rising edge of read enable). When not busy, bit 6 is array data and does not toggle.
- R8: The busy period lasts exactly PROG_CYCLES clock cycles. It ends one cycle after the internal program counter reaches zero.
- R9: Byte loads that arrive while busy are ignored. They change neither the buffer nor the array, and they start no new commit.
- R10: A load to a sector that differs from the bound sector of an open page discards the earlier loads and restarts the page on the new sector.
- R11: After reset the block is idle, every stored byte is 8'hFF, and dout_en is 0 while the strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 19 | Byte address: [18:8] sector, [7:0] offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status word |
| dout_en | output | 1 | Data bus driven; 0 stands for high impedance |

## Verification
The hardest case to reach from the pins is the exact cycle bounds of the busy window. It opens only after an idle gap that follows the last load, and it is visible only through the inverted bit 7 of a read. The bench ends the final write and opens a single long read in the same cycle. It then samples bit 7 every cycle and checks both the first busy cycle and the total count of busy cycles. Dropped loads are tested by writing while busy. The bench then waits well past a full load window and reads the target byte back.

// File: rtl/spb_pkg.sv
package spb_pkg;
  localparam int ADDR_W     = 19;
  localparam int DATA_W     = 8;
  localparam int OFF_W      = 8;
  localparam int SECT_W     = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LOAD = 2'd1,
    PS_BUSY = 2'd2
  } pstate_t;
endpackage

// File: rtl/spb_page_buf.sv
module spb_page_buf
  import spb_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ok,
  input  logic              busy,
  input  logic              page_done,
  input  logic [SECT_W-1:0] ld_sect,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_loaded,
  output logic [SW-1:0]     pg_sect_lo,
  output logic              last_b7
);
  logic [DATA_W-1:0]     bytes_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] flags_q;
  logic [SECT_W-1:0]     sect_q;
  logic                  open_q;
  logic                  new_page;

  assign new_page = !open_q || (ld_sect != sect_q);

  always_ff @(posedge clk) begin
    if (load_ok) bytes_q[ld_off] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sect_q  <= '0;
      open_q  <= 1'b0;
      last_b7 <= 1'b0;
    end else if (load_ok) begin
      open_q  <= 1'b1;
      sect_q  <= ld_sect;
      last_b7 <= ld_data[DATA_W-1];
      if (new_page) begin
        flags_q         <= '0;
        flags_q[ld_off] <= 1'b1;
      end else begin
        flags_q[ld_off] <= 1'b1;
      end
    end else if (page_done) begin
      open_q <= 1'b0;
    end
  end

  assign rd_data    = bytes_q[rd_off];
  assign rd_loaded  = flags_q[rd_off];
  assign pg_sect_lo = sect_q[SW-1:0];

  // R10: a load to a foreign sector leaves exactly one byte marked
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && open_q && ld_sect != sect_q) |=> ($countones(flags_q) == 1));
  // R9: page contents frozen while the commit runs
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(flags_q) && $stable(sect_q)));
endmodule

// File: rtl/spb_prog_ctrl.sv
module spb_prog_ctrl
  import spb_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 40,
  parameter int PROG_CYCLES  = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             loaded,
  output logic             load_ok,
  output logic             busy,
  output logic             page_done,
  output logic             arr_we,
  output logic             arr_fill,
  output logic [OFF_W-1:0] arr_off
);
  localparam int LW = $clog2(LOAD_TIMEOUT + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam int QW = OFF_W + 2;

  pstate_t        st_q;
  logic [LW-1:0]  ld_cnt_q;
  logic [PW-1:0]  rem_q;
  logic [QW-1:0]  ptr_q;
  logic           walking;
  logic           erasing;

  assign busy      = (st_q == PS_BUSY);
  assign load_ok   = load && !busy;
  assign page_done = busy && (rem_q == '0);
  assign walking   = busy && !ptr_q[QW-1];
  assign erasing   = (ptr_q[QW-2] == 1'b0);
  assign arr_off   = ptr_q[OFF_W-1:0];
  assign arr_fill  = erasing;
  assign arr_we    = walking && (erasing || loaded);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_IDLE;
      ld_cnt_q <= '0;
      rem_q    <= '0;
      ptr_q    <= '0;
    end else begin
      case (st_q)
        PS_IDLE: begin
          if (load_ok) begin
            st_q     <= PS_LOAD;
            ld_cnt_q <= LW'(LOAD_TIMEOUT);
          end
        end
        PS_LOAD: begin
          if (load_ok) begin
            ld_cnt_q <= LW'(LOAD_TIMEOUT);
          end else if (ld_cnt_q == '0) begin
            st_q  <= PS_BUSY;
            rem_q <= PW'(PROG_CYCLES - 1);
            ptr_q <= '0;
          end else begin
            ld_cnt_q <= ld_cnt_q - 1'b1;
          end
        end
        PS_BUSY: begin
          if (walking) ptr_q <= ptr_q + 1'b1;
          if (rem_q == '0) st_q <= PS_IDLE;
          else             rem_q <= rem_q - 1'b1;
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  // R8: busy drops the cycle after the counter reaches zero
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !busy);
  // R8: busy holds while the counter is nonzero
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem_q != '0) |=> busy);
  // R4: the commit only starts from an expired load window
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ld_cnt_q) == '0 && $past(st_q) == PS_LOAD));
endmodule

// File: rtl/spb_array.sv
module spb_array
  import spb_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SW-1:0]     wsect,
  input  logic [OFF_W-1:0]  woff,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SW-1:0]     rsect,
  input  logic [OFF_W-1:0]  roff,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = (1 << SW) * PAGE_BYTES;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we) begin
      mem_q[{wsect, woff}] <= wdata;
    end
  end

  assign rdata = mem_q[{rsect, roff}];
endmodule

// File: rtl/spb_engine.sv
module spb_engine
  import spb_pkg::*;
#(
  parameter int LOAD_TIMEOUT  = 40,
  parameter int PROG_CYCLES   = 600,
  parameter int MODEL_SECTORS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int SW = (MODEL_SECTORS > 1) ? $clog2(MODEL_SECTORS) : 1;

  logic              wr_act, wr_q, load;
  logic              rd_q, rd_start, tog_q;
  logic              load_ok, busy, page_done;
  logic              arr_we, arr_fill, loaded, last_b7;
  logic [OFF_W-1:0]  arr_off;
  logic [DATA_W-1:0] buf_byte, arr_wdata, arr_rdata;
  logic [SW-1:0]     pg_sect_lo;

  assign wr_act   = !ce_n && !we_n && oe_n;
  assign load     = wr_act && !wr_q;
  assign dout_en  = !ce_n && !oe_n;
  assign rd_start = dout_en && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= dout_en;
      if (busy && rd_start) tog_q <= !tog_q;
    end
  end

  spb_prog_ctrl #(
    .LOAD_TIMEOUT (LOAD_TIMEOUT),
    .PROG_CYCLES  (PROG_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .loaded    (loaded),
    .load_ok   (load_ok),
    .busy      (busy),
    .page_done (page_done),
    .arr_we    (arr_we),
    .arr_fill  (arr_fill),
    .arr_off   (arr_off)
  );

  spb_page_buf #(.SW(SW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_ok    (load_ok),
    .busy       (busy),
    .page_done  (page_done),
    .ld_sect    (addr[ADDR_W-1:OFF_W]),
    .ld_off     (addr[OFF_W-1:0]),
    .ld_data    (din),
    .rd_off     (arr_off),
    .rd_data    (buf_byte),
    .rd_loaded  (loaded),
    .pg_sect_lo (pg_sect_lo),
    .last_b7    (last_b7)
  );

  assign arr_wdata = arr_fill ? '1 : buf_byte;

  spb_array #(.SW(SW)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (arr_we),
    .wsect (pg_sect_lo),
    .woff  (arr_off),
    .wdata (arr_wdata),
    .rsect (addr[OFF_W+SW-1:OFF_W]),
    .roff  (addr[OFF_W-1:0]),
    .rdata (arr_rdata)
  );

  always_comb begin
    if (busy) dout = {!last_b7, tog_q, 6'b0};
    else      dout = arr_rdata;
  end

  // R5: the array is only written inside the commit window
  p_arr_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R7: the toggle bit stays put outside the commit window
  p_tog_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog_q));
  // R2: a load with output enable low is never taken
  p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !load_ok);
endmodule

// File: tb/spb_engine_bench.sv
module spb_engine_bench;
  localparam int LT = 40;
  localparam int PC = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = !clk;

  spb_engine #(.LOAD_TIMEOUT(LT), .PROG_CYCLES(PC), .MODEL_SECTORS(4)) u_spb_engine (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [18:0] ad(input int s, input int o);
    return {11'(s), 8'(o)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 0; oe_n = 1; we_n = 0; addr = a; din = d;
    @(negedge clk);
    we_n = 1; ce_n = 1;
  endtask

  task automatic rd(input logic [18:0] a, output logic [7:0] d);
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk);
    d = dout;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic poll(input logic [18:0] a, input logic [7:0] e);
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(a, v);
      if (v == e) break;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R11 dout_en idle", dout_en, 0);
    rd(ad(0, 0), v);  check("R11 erased byte", v, 8'hFF);
    rd(ad(3, 255), v); check("R1 read stored", v, 8'hFF);
  endtask

  task automatic t_hiz;
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1;
    @(negedge clk); check("R1 oe high hiz", dout_en, 0);
    ce_n = 1; oe_n = 0;
    @(negedge clk); check("R1 ce high hiz", dout_en, 0);
    ce_n = 0;
    @(negedge clk); check("R1 driven", dout_en, 1);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic t_window;
    int first = -1;
    int cnt = 0;
    for (int i = 0; i < 3; i++) wr(ad(1, i), 8'(8'hA0 + i));
    @(negedge clk);
    ce_n = 0; oe_n = 1; we_n = 0; addr = ad(1, 3); din = 8'h85;
    @(negedge clk);
    we_n = 1; oe_n = 0;
    for (int k = 1; k <= LT + PC + 20; k++) begin
      @(negedge clk);
      if (dout[7] == 1'b0) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
    ce_n = 1; oe_n = 1;
    check("R4 first busy cycle", first, LT + 1);
    check("R8 busy length", cnt, PC);
  endtask

  task automatic t_result;
    logic [7:0] v;
    rd(ad(1, 0), v); check("R3 off0", v, 8'hA0);
    rd(ad(1, 2), v); check("R3 off2", v, 8'hA2);
    rd(ad(1, 3), v); check("R5 last", v, 8'h85);
    rd(ad(1, 4), v); check("R5 unloaded", v, 8'hFF);
    rd(ad(0, 0), v); check("R5 other sector", v, 8'hFF);
  endtask

  task automatic t_poll_ignore;
    logic [7:0] a, b;
    wr(ad(2, 7), 8'h12);
    idle(LT + 3);
    rd(ad(2, 7), a);
    rd(ad(2, 7), b);
    check("R6 inverted b7", a[7], 1);
    check("R6 low bits", a[5:0], 0);
    check("R7 toggles", a[6] ^ b[6], 1);
    wr(ad(2, 9), 8'h33);
    poll(ad(2, 7), 8'h12);
    rd(ad(2, 7), a);
    rd(ad(2, 7), b);
    check("R7 true data", a, 8'h12);
    check("R7 no toggle idle", a[6] ^ b[6], 0);
    idle(LT + 10);
    rd(ad(2, 9), a); check("R9 dropped load", a, 8'hFF);
    rd(ad(2, 7), a); check("R9 no new commit", a, 8'h12);
  endtask

  task automatic t_rewrite;
    logic [7:0] v;
    wr(ad(1, 2), 8'h5A);
    poll(ad(1, 2), 8'h5A);
    rd(ad(1, 2), v); check("R5 reprog", v, 8'h5A);
    rd(ad(1, 0), v); check("R5 erased old", v, 8'hFF);
    rd(ad(1, 3), v); check("R5 erased last", v, 8'hFF);
  endtask

  task automatic t_restart;
    logic [7:0] v;
    wr(ad(3, 0), 8'h11);
    wr(ad(3, 1), 8'h22);
    wr(ad(0, 4), 8'h44);
    poll(ad(0, 4), 8'h44);
    rd(ad(0, 4), v); check("R10 new sector byte", v, 8'h44);
    rd(ad(3, 0), v); check("R10 old sector dropped", v, 8'hFF);
    rd(ad(3, 1), v); check("R10 old sector dropped b", v, 8'hFF);
    rd(ad(2, 7), v); check("R5 untouched sector", v, 8'h12);
  endtask

  task automatic t_inhibit;
    logic [7:0] v;
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = ad(0, 8); din = 8'h77;
    idle(2);
    ce_n = 1; oe_n = 1; we_n = 0;
    idle(3);
    we_n = 1;
    idle(LT + 10);
    rd(ad(0, 8), v); check("R2 inhibited byte", v, 8'hFF);
    rd(ad(0, 4), v); check("R2 no commit", v, 8'h44);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_hiz();
    t_window();
    t_result();
    t_poll_ignore();
    t_rewrite();
    t_restart();
    t_inhibit();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule